// File: doc/BRIEF.md
# System Options Register with Write-Once Locking

This block is an 8-bit system configuration register. It holds five controls: watchdog enable, watchdog period select, stop-mode permission, debug-pin enable and reset-pin enable. Boot code normally writes it once early on. The first CPU write after any reset sets a lock, and from then on the watchdog, period, stop and reset-pin bits ignore further writes. The debug-pin enable follows its own rule. It may only be cleared by software, and that clear is still accepted after the lock is set.

On a reset, the debug-pin enable takes a value chosen from two inputs sampled during the reset cycle: a boot-mode level and a security flag. The reset-pin enable survives ordinary resets and is cleared only by power-on reset. The block also watches stop requests from the core. A request that starts while stop is permitted yields a stop grant pulse. A request that starts while stop is forbidden yields a one-cycle illegal-operation reset request.

Top module: `sys_opt_reg`

## Requirements
- R1: On any reset (por_i or rst_i high at a clock edge), after that edge the watchdog enable is 1, the period select is 1, the stop permission is 0, and the write lock is clear.
- R2: The first write strobe after reset loads bit 7 (watchdog enable), bit 6 (period select, 1 = long), bit 5 (stop permission) and bit 0 (reset-pin enable) from wr_data_i. Later writes before the next reset leave those four bits unchanged.
- R3: A reset with mode_sel_i high loads the debug-pin enable with sec_open_i (1 = security disengaged).
- R4: A reset with mode_sel_i low loads the debug-pin enable with 1.
- R5: A write with bit 1 of wr_data_i at 0 clears the debug-pin enable, whether or not the lock is set. A write with bit 1 at 1 leaves it unchanged, so software can never set it.
- R6: Power-on reset clears the reset-pin enable. An ordinary reset (rst_i alone) keeps its value.
- R7: Each field output mirrors its register bit, and rst_pullup_o is high exactly when the reset-pin enable is 1.
- R8: A rising edge of stop_req_i (high now, low in the previous cycle, no reset) while stop permission is 0 drives illegal_rst_o high for exactly the next cycle.
- R9: A rising edge of stop_req_i while stop permission is 1 drives stop_ok_o high for the next cycle, and illegal_rst_o stays low.
- R10: rd_data_o returns {watchdog enable, period select, stop permission, 3'b000, debug-pin enable, reset-pin enable}, from bit 7 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| rst_i | input | 1 | Ordinary reset, synchronous, active high |
| mode_sel_i | input | 1 | Boot-mode level sampled during reset (0 = debug boot) |
| sec_open_i | input | 1 | High when security is disengaged |
| wr_en_i | input | 1 | CPU write strobe |
| wr_data_i | input | 8 | CPU write data |
| stop_req_i | input | 1 | Stop request from the core |
| rd_data_o | output | 8 | Register read value |
| wdog_en_o | output | 1 | Watchdog enable |
| wdog_long_o | output | 1 | Watchdog period select, 1 = long |
| stop_en_o | output | 1 | Stop permission |
| dbg_pin_en_o | output | 1 | Debug-pin enable |
| rst_pin_en_o | output | 1 | Reset-pin enable |
| rst_pullup_o | output | 1 | Pull-up enable for the reset pin |
| illegal_rst_o | output | 1 | Illegal-operation reset request pulse |
| stop_ok_o | output | 1 | Stop grant pulse |

## Verification
A lock flag stuck high shows on rd_data_o in the cycle after the first write following a reset, because that write fails to land. A lock flag stuck low shows one cycle after the second write, because that write overwrites the bits. A debug-pin enable with a wrong reset value is visible on rd_data_o right after the reset edge. A stale edge-detect register shows up as a missing or repeated pulse on illegal_rst_o or stop_ok_o one cycle after a stop request. The bench compares every output after every clock edge, so any such fault is caught within a cycle of the stimulus that exposes it.

// File: rtl/sopt_pkg.sv
package sopt_pkg;
    localparam int REG_W   = 8;
    localparam int BIT_WDE = 7;
    localparam int BIT_WDL = 6;
    localparam int BIT_STE = 5;
    localparam int BIT_DBG = 1;
    localparam int BIT_RPE = 0;

    typedef struct packed {
        logic wd_en;
        logic wd_long;
        logic stop_en;
        logic dbg_en;
        logic rpin_en;
    } sopt_fields_t;

    typedef struct packed {
        logic req_prev;
        logic illegal;
        logic ok;
    } sopt_stop_t;
endpackage

// File: rtl/sopt_lock.sv
module sopt_lock (
    input  logic clk,
    input  logic por_i,
    input  logic rst_i,
    input  logic wr_en_i,
    output logic lock_o
);
    logic lock_d, lock_q;

    always_comb begin
        lock_d = lock_q;
        if (wr_en_i) lock_d = 1'b1;
        if (por_i || rst_i) lock_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        lock_q <= lock_d;
    end

    assign lock_o = lock_q;
endmodule

// File: rtl/sopt_fields.sv
module sopt_fields
    import sopt_pkg::*;
#(
    parameter logic WDE_RST = 1'b1,
    parameter logic WDL_RST = 1'b1,
    parameter logic STE_RST = 1'b0
) (
    input  logic             clk,
    input  logic             por_i,
    input  logic             rst_i,
    input  logic             mode_sel_i,
    input  logic             sec_open_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             lock_i,
    output sopt_fields_t     fld_o
);
    sopt_fields_t fld_d, fld_q;
    logic unused_bits;

    assign unused_bits = ^wr_data_i;

    always_comb begin
        fld_d = fld_q;
        if (wr_en_i) begin
            if (!lock_i) begin
                fld_d.wd_en   = wr_data_i[BIT_WDE];
                fld_d.wd_long = wr_data_i[BIT_WDL];
                fld_d.stop_en = wr_data_i[BIT_STE];
                fld_d.rpin_en = wr_data_i[BIT_RPE];
            end
            // one-way clear, not blocked by the lock
            fld_d.dbg_en = fld_q.dbg_en & wr_data_i[BIT_DBG];
        end
        if (por_i || rst_i) begin
            fld_d.wd_en   = WDE_RST;
            fld_d.wd_long = WDL_RST;
            fld_d.stop_en = STE_RST;
            fld_d.dbg_en  = !mode_sel_i || sec_open_i;
            fld_d.rpin_en = por_i ? 1'b0 : fld_q.rpin_en;
        end
    end

    always_ff @(posedge clk) begin
        fld_q <= fld_d;
    end

    assign fld_o = fld_q;
endmodule

// File: rtl/sopt_stop.sv
module sopt_stop
    import sopt_pkg::*;
(
    input  logic clk,
    input  logic por_i,
    input  logic rst_i,
    input  logic stop_req_i,
    input  logic stop_en_i,
    output logic illegal_o,
    output logic ok_o
);
    sopt_stop_t st_d, st_q;
    logic       req_rise;

    assign req_rise = stop_req_i && !st_q.req_prev;

    always_comb begin
        st_d.req_prev = stop_req_i;
        st_d.illegal  = req_rise && !stop_en_i;
        st_d.ok       = req_rise && stop_en_i;
        if (por_i || rst_i) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign illegal_o = st_q.illegal;
    assign ok_o      = st_q.ok;
endmodule

// File: rtl/sys_opt_reg.sv
module sys_opt_reg
    import sopt_pkg::*;
#(
    parameter logic WDE_RST = 1'b1,
    parameter logic WDL_RST = 1'b1,
    parameter logic STE_RST = 1'b0
) (
    input  logic             clk,
    input  logic             por_i,
    input  logic             rst_i,
    input  logic             mode_sel_i,
    input  logic             sec_open_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             stop_req_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic             wdog_en_o,
    output logic             wdog_long_o,
    output logic             stop_en_o,
    output logic             dbg_pin_en_o,
    output logic             rst_pin_en_o,
    output logic             rst_pullup_o,
    output logic             illegal_rst_o,
    output logic             stop_ok_o
);
    logic         lock_w;
    sopt_fields_t fld_w;

    sopt_lock u_lock (
        .clk     (clk),
        .por_i   (por_i),
        .rst_i   (rst_i),
        .wr_en_i (wr_en_i),
        .lock_o  (lock_w)
    );

    sopt_fields #(
        .WDE_RST (WDE_RST),
        .WDL_RST (WDL_RST),
        .STE_RST (STE_RST)
    ) u_fields (
        .clk        (clk),
        .por_i      (por_i),
        .rst_i      (rst_i),
        .mode_sel_i (mode_sel_i),
        .sec_open_i (sec_open_i),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .lock_i     (lock_w),
        .fld_o      (fld_w)
    );

    sopt_stop u_stop (
        .clk        (clk),
        .por_i      (por_i),
        .rst_i      (rst_i),
        .stop_req_i (stop_req_i),
        .stop_en_i  (fld_w.stop_en),
        .illegal_o  (illegal_rst_o),
        .ok_o       (stop_ok_o)
    );

    always_comb begin
        rd_data_o          = '0;
        rd_data_o[BIT_WDE] = fld_w.wd_en;
        rd_data_o[BIT_WDL] = fld_w.wd_long;
        rd_data_o[BIT_STE] = fld_w.stop_en;
        rd_data_o[BIT_DBG] = fld_w.dbg_en;
        rd_data_o[BIT_RPE] = fld_w.rpin_en;
    end

    assign wdog_en_o    = fld_w.wd_en;
    assign wdog_long_o  = fld_w.wd_long;
    assign stop_en_o    = fld_w.stop_en;
    assign dbg_pin_en_o = fld_w.dbg_en;
    assign rst_pin_en_o = fld_w.rpin_en;
    assign rst_pullup_o = fld_w.rpin_en;
endmodule

// File: rtl/sopt_chk.sv
module sopt_chk (
    input logic clk,
    input logic por_i,
    input logic rst_i,
    input logic mode_sel_i,
    input logic sec_open_i,
    input logic wr_en_i,
    input logic stop_req_i,
    input logic lock_i,
    input logic wde_i,
    input logic wdl_i,
    input logic ste_i,
    input logic dbg_i,
    input logic rpe_i,
    input logic ill_i,
    input logic ok_i
);
    logic req_prev_q;

    always_ff @(posedge clk) begin
        if (por_i || rst_i) req_prev_q <= 1'b0;
        else                req_prev_q <= stop_req_i;
    end

    p_reset_vals_r1: assert property (@(posedge clk)
        (por_i || rst_i) |=> (wde_i && wdl_i && !ste_i && !lock_i));

    p_lock_set_r2: assert property (@(posedge clk) disable iff (por_i)
        (wr_en_i && !rst_i) |=> lock_i);

    p_lock_hold_r2: assert property (@(posedge clk) disable iff (por_i)
        (lock_i && !rst_i) |=> ($stable(wde_i) && $stable(wdl_i) && $stable(ste_i) && $stable(rpe_i)));

    p_dbg_normal_r3: assert property (@(posedge clk) disable iff (por_i)
        (rst_i && mode_sel_i) |=> (dbg_i == $past(sec_open_i)));

    p_dbg_debug_r4: assert property (@(posedge clk) disable iff (por_i)
        (rst_i && !mode_sel_i) |=> dbg_i);

    p_dbg_oneway_r5: assert property (@(posedge clk) disable iff (por_i)
        (!rst_i && !dbg_i) |=> !dbg_i);

    p_por_rpe_r6: assert property (@(posedge clk)
        por_i |=> !rpe_i);

    p_rst_rpe_r6: assert property (@(posedge clk) disable iff (por_i)
        rst_i |=> $stable(rpe_i));

    p_illegal_r8: assert property (@(posedge clk) disable iff (por_i)
        (!rst_i && stop_req_i && !req_prev_q && !ste_i) |=> ill_i);

    p_illegal_pulse_r8: assert property (@(posedge clk) disable iff (por_i)
        ill_i |=> !ill_i);

    p_stop_ok_r9: assert property (@(posedge clk) disable iff (por_i)
        (!rst_i && stop_req_i && !req_prev_q && ste_i) |=> (ok_i && !ill_i));
endmodule

bind sys_opt_reg sopt_chk u_chk (
    .clk        (clk),
    .por_i      (por_i),
    .rst_i      (rst_i),
    .mode_sel_i (mode_sel_i),
    .sec_open_i (sec_open_i),
    .wr_en_i    (wr_en_i),
    .stop_req_i (stop_req_i),
    .lock_i     (lock_w),
    .wde_i      (wdog_en_o),
    .wdl_i      (wdog_long_o),
    .ste_i      (stop_en_o),
    .dbg_i      (dbg_pin_en_o),
    .rpe_i      (rst_pin_en_o),
    .ill_i      (illegal_rst_o),
    .ok_i       (stop_ok_o)
);

// File: tb/test_sys_opt_reg.sv
module test_sys_opt_reg;
    logic       clk = 1'b0;
    logic       por_i = 1'b1, rst_i = 1'b0, mode_sel_i = 1'b1, sec_open_i = 1'b0;
    logic       wr_en_i = 1'b0, stop_req_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] rd_data_o;
    logic       wdog_en_o, wdog_long_o, stop_en_o, dbg_pin_en_o, rst_pin_en_o;
    logic       rst_pullup_o, illegal_rst_o, stop_ok_o;

    int total = 0;
    int bad   = 0;

    // reference state, built from the requirements
    logic m_wde, m_wdl, m_ste, m_dbg, m_rpe, m_lock, m_prev;
    logic e_ill = 1'b0, e_ok = 1'b0;

    always #5 clk = ~clk;

    sys_opt_reg i_sys_opt_reg (
        .clk(clk), .por_i(por_i), .rst_i(rst_i), .mode_sel_i(mode_sel_i),
        .sec_open_i(sec_open_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .stop_req_i(stop_req_i), .rd_data_o(rd_data_o), .wdog_en_o(wdog_en_o),
        .wdog_long_o(wdog_long_o), .stop_en_o(stop_en_o), .dbg_pin_en_o(dbg_pin_en_o),
        .rst_pin_en_o(rst_pin_en_o), .rst_pullup_o(rst_pullup_o),
        .illegal_rst_o(illegal_rst_o), .stop_ok_o(stop_ok_o)
    );

    function automatic logic [7:0] exp_rd();
        return {m_wde, m_wdl, m_ste, 3'b000, m_dbg, m_rpe};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic p, input logic r, input logic m, input logic s,
                        input logic we, input logic [7:0] wd, input logic sr);
        @(negedge clk);
        por_i = p; rst_i = r; mode_sel_i = m; sec_open_i = s;
        wr_en_i = we; wr_data_i = wd; stop_req_i = sr;
        @(posedge clk);
        e_ill = !(p || r) && sr && !m_prev && !m_ste;
        e_ok  = !(p || r) && sr && !m_prev && m_ste;
        if (p || r) begin
            m_wde = 1'b1; m_wdl = 1'b1; m_ste = 1'b0; m_lock = 1'b0; m_prev = 1'b0;
            m_dbg = !m || s;
            if (p) m_rpe = 1'b0;
        end else begin
            if (we) begin
                if (!m_lock) begin
                    m_wde = wd[7]; m_wdl = wd[6]; m_ste = wd[5]; m_rpe = wd[0];
                end
                m_dbg  = m_dbg & wd[1];
                m_lock = 1'b1;
            end
            m_prev = sr;
        end
        #1;
        check("R10", rd_data_o, exp_rd());
        check("R7", {3'b0, wdog_en_o, wdog_long_o, stop_en_o, dbg_pin_en_o, rst_pin_en_o},
              {3'b0, m_wde, m_wdl, m_ste, m_dbg, m_rpe});
        check("R7", {7'b0, rst_pullup_o}, {7'b0, m_rpe});
        check("R8", {7'b0, illegal_rst_o}, {7'b0, e_ill});
        check("R9", {7'b0, stop_ok_o}, {7'b0, e_ok});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_rpe = 1'b0; m_wde = 1'b1; m_wdl = 1'b1; m_ste = 1'b0;
        m_dbg = 1'b0; m_lock = 1'b0; m_prev = 1'b0;
        // R1 R3 R6: power-on into normal mode, security engaged
        step(1, 0, 1, 0, 0, 8'h00, 0);
        step(1, 0, 1, 0, 0, 8'h00, 0);
        check("R1", rd_data_o, 8'hC0);
        // R4: ordinary reset into debug mode sets debug-pin enable
        step(0, 1, 0, 0, 0, 8'h00, 0);
        check("R4", rd_data_o, 8'hC2);
        // R2 R5: first write loads fields and clears debug bit
        step(0, 0, 1, 0, 1, 8'h21, 0);
        check("R2", rd_data_o, 8'h21);
        // R2 R5: second write ignored, debug bit cannot be set
        step(0, 0, 1, 0, 1, 8'hE2, 0);
        check("R5", rd_data_o, 8'h21);
        // R9: stop permitted
        step(0, 0, 1, 0, 0, 8'h00, 1);
        check("R9", {7'b0, stop_ok_o}, 8'h01);
        step(0, 0, 1, 0, 0, 8'h00, 1);
        check("R9", {7'b0, stop_ok_o}, 8'h00);
        step(0, 0, 1, 0, 0, 8'h00, 0);
        // R6 R3: ordinary reset keeps reset-pin enable, security open
        step(0, 1, 1, 1, 0, 8'h00, 0);
        check("R6", rd_data_o, 8'hC3);
        // R8: stop forbidden gives one pulse while request is held
        step(0, 0, 1, 1, 0, 8'h00, 1);
        check("R8", {7'b0, illegal_rst_o}, 8'h01);
        step(0, 0, 1, 1, 0, 8'h00, 1);
        check("R8", {7'b0, illegal_rst_o}, 8'h00);
        // R5: clear of debug bit after lock is still accepted
        step(0, 0, 1, 1, 1, 8'hC3, 0);
        step(0, 0, 1, 1, 1, 8'h00, 0);
        check("R5", rd_data_o, 8'hC1);
        // R6: power-on clears reset-pin enable
        step(1, 0, 1, 1, 0, 8'h00, 0);
        check("R6", {7'b0, rst_pullup_o}, 8'h00);
        // random phase
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            logic p, r, we, sr;
            p  = ($urandom % 64) == 0;
            r  = ($urandom % 24) == 0;
            we = ($urandom % 4) == 0;
            sr = ($urandom % 3) == 0;
            step(p, r, 1'($urandom), 1'($urandom), we, 8'($urandom), sr);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule